// File: doc/BRIEF.md
# Pipelined Burst SRAM Cycle Controller

This block models a synchronous burst static memory with a small parameterized array. On every rising clock edge it looks at two address strobes, three chip enables, the burst-advance input and the write-enable group. From these it decides whether the cycle is a deselect, the start of a new access, a step to the next burst address, or a suspend that holds the current address. The processor strobe outranks the controller strobe, but the master chip enable can block it. The controller strobe is never blocked.

Writes are masked per byte, and a global write enable overrides the per-byte strobes. Read data leaves through one of two paths, chosen by a static input: an output register that adds one clock of latency, or a flow-through path that shows the array word in the same cycle as the registered address. An asynchronous output enable qualifies the data output.

Data in and data out are separate ports. `rdata_vld` stands in for a tristate bus. It is a plain qualifier with no back-pressure: the consumer cannot stall the block, and the only way to slow a burst is to hold the advance input inactive.

Top module: `bsram_ctrl`

## Requirements
- R1: While reset is held, and on the first cycle after it is released, the block is deselected and `rdata_vld` is 0.
- R2: When the processor strobe is low with the master enable active, the block starts a read at `addr`. This holds whatever the controller strobe, the global write enable, the byte-write enable and the byte strobes show, and no array byte is written on that edge.
- R3: When the master enable is high, a low processor strobe counts as no strobe: a running burst keeps holding or stepping as if neither strobe were low.
- R4: The controller strobe starts an access only if the processor strobe is high on that edge or is blocked by the master enable. The write enables seen on that same edge decide between read and write.
- R5: Byte lane n is `wdata[9n+8:9n]`. A low `wr_all_n` writes every lane. Otherwise lane n is written only when `wr_byte_en_n` and `byte_stb_n[n]` are both low. With no lane selected the cycle is a read.
- R6: A starting strobe seen while `ce_main_n` is high, `ce_lo_n` is high or `ce_hi` is low deselects the block. In flow-through mode `rdata_vld` is 0 from the next cycle. In pipelined mode the read already in flight is shown for one cycle, and then `rdata_vld` is 0.
- R7: On an edge with no effective strobe and `adv_n` low, the access moves to the next burst address. The two low address bits follow base XOR count when `burst_linear` is 0, and base plus count modulo 4 when it is 1. The upper bits stay fixed.
- R8: On an edge with no effective strobe and `adv_n` high, the address is held and the same word keeps being presented.
- R9: With `flow_thru` = 1, data for the address registered on an edge appears right after that edge. With `flow_thru` = 0 it appears after the following edge.
- R10: `oe_n` high forces `rdata_vld` to 0 at once, with no clock involved.
- R11: An edge that writes any lane disables the output regardless of `oe_n`. This covers the cycle after it in both modes, including a pipelined read that was still in flight.
- R12: On continuation edges the write enables are sampled every cycle, and a write goes to the address the block moves to on that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| addr | input | AW | Start address for a new access |
| proc_stb_n | input | 1 | Processor address strobe, active low, higher priority |
| ctrl_stb_n | input | 1 | Controller address strobe, active low |
| adv_n | input | 1 | Burst advance, active low |
| ce_main_n | input | 1 | Master chip enable, active low, blocks the processor strobe |
| ce_lo_n | input | 1 | Secondary chip enable, active low |
| ce_hi | input | 1 | Secondary chip enable, active high |
| wr_all_n | input | 1 | Global write enable, active low, writes every lane |
| wr_byte_en_n | input | 1 | Byte-write enable, active low, qualifies the byte strobes |
| byte_stb_n | input | NB | Per-lane write strobes, active low |
| oe_n | input | 1 | Asynchronous output enable, active low |
| flow_thru | input | 1 | Static read-path select: 1 flow-through, 0 pipelined |
| burst_linear | input | 1 | Static burst order: 1 linear, 0 interleaved (XOR) |
| wdata | input | NB*BW | Write data |
| rdata | output | NB*BW | Read data |
| rdata_vld | output | 1 | Read data is being driven |

## Verification
Two functions can land on the same edge. The first case is a pipelined read still draining while a write or a deselect is sampled. The bench provokes it by following a pipelined step with a write step and, later, by deselecting right after a step. It expects the write to suppress the drained word, while the deselect lets that word through for exactly one cycle. The second case is both strobes low together with write enables active. The bench judges this from the data returned on that edge, which must be the old word and not the write data.

// File: rtl/bsram_pkg.sv
`timescale 1ns/1ps
package bsram_pkg;
  // Per-edge classification of the strobe and enable inputs
  typedef enum logic [2:0] {
    CMD_IDLE  = 3'd0,  // deselected and no strobe: nothing happens
    CMD_DESEL = 3'd1,  // strobe with a chip enable inactive
    CMD_START = 3'd2,  // new access at the external address
    CMD_STEP  = 3'd3,  // continue, move to next burst address
    CMD_HOLD  = 3'd4   // suspend, keep current address
  } cmd_e;
endpackage

// File: rtl/bsram_decode.sv
`timescale 1ns/1ps
module bsram_decode
  import bsram_pkg::*;
#(
  parameter int NB = 2
) (
  input  logic          proc_stb_n,
  input  logic          ctrl_stb_n,
  input  logic          adv_n,
  input  logic          ce_main_n,
  input  logic          ce_lo_n,
  input  logic          ce_hi,
  input  logic          wr_all_n,
  input  logic          wr_byte_en_n,
  input  logic [NB-1:0] byte_stb_n,
  input  logic          active_q,
  output cmd_e          cmd,
  output logic [NB-1:0] wmask
);
  logic          proc_eff, ctrl_eff, ces_ok;
  logic [NB-1:0] lane_req;

  // per-lane request: global override or qualified byte strobe
  for (genvar g = 0; g < NB; g++) begin : g_lane
    assign lane_req[g] = !wr_all_n || (!wr_byte_en_n && !byte_stb_n[g]);
  end

  assign proc_eff = !proc_stb_n && !ce_main_n;
  assign ctrl_eff = !ctrl_stb_n && !proc_eff;
  assign ces_ok   = !ce_main_n && !ce_lo_n && ce_hi;

  always_comb begin
    cmd   = CMD_IDLE;
    wmask = '0;
    if (proc_eff || ctrl_eff) begin
      if (!ces_ok) begin
        cmd = CMD_DESEL;
      end else begin
        cmd = CMD_START;
        // processor-started cycles are always reads
        if (ctrl_eff) wmask = lane_req;
      end
    end else if (active_q) begin
      cmd   = adv_n ? CMD_HOLD : CMD_STEP;
      wmask = lane_req;
    end
  end
endmodule

// File: rtl/bsram_burst.sv
`timescale 1ns/1ps
module bsram_burst #(
  parameter int AW = 6,
  parameter int BB = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic          step,
  input  logic          linear,
  input  logic [AW-1:0] load_addr,
  output logic [AW-1:0] cur_addr,
  output logic [AW-1:0] nxt_addr
);
  logic [AW-1:0] base_q;
  logic [BB-1:0] cnt_q, cnt_inc;

  function automatic logic [BB-1:0] order(input logic [BB-1:0] lo,
                                          input logic [BB-1:0] cnt,
                                          input logic          lin);
    return lin ? (lo + cnt) : (lo ^ cnt);
  endfunction

  assign cnt_inc  = cnt_q + 1'b1;
  assign cur_addr = {base_q[AW-1:BB], order(base_q[BB-1:0], cnt_q, linear)};

  always_comb begin
    if (load)      nxt_addr = load_addr;
    else if (step) nxt_addr = {base_q[AW-1:BB], order(base_q[BB-1:0], cnt_inc, linear)};
    else           nxt_addr = cur_addr;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q <= '0;
      cnt_q  <= '0;
    end else if (load) begin
      base_q <= load_addr;
      cnt_q  <= '0;
    end else if (step) begin
      cnt_q  <= cnt_inc;
    end
  end
endmodule

// File: rtl/bsram_array.sv
`timescale 1ns/1ps
module bsram_array #(
  parameter int AW  = 6,
  parameter int NB  = 2,
  parameter int BYW = 9
) (
  input  logic              clk,
  input  logic [NB-1:0]     we,
  input  logic [AW-1:0]     waddr,
  input  logic [NB*BYW-1:0] wdata,
  input  logic [AW-1:0]     raddr,
  output logic [NB*BYW-1:0] rdata
);
  localparam int DEPTH = 1 << AW;

  for (genvar g = 0; g < NB; g++) begin : g_lane
    logic [BYW-1:0] lane_mem [DEPTH];
    always_ff @(posedge clk) begin
      if (we[g]) lane_mem[waddr] <= wdata[g*BYW +: BYW];
    end
    assign rdata[g*BYW +: BYW] = lane_mem[raddr];
  end
endmodule

// File: rtl/bsram_ctrl.sv
`timescale 1ns/1ps
module bsram_ctrl
  import bsram_pkg::*;
#(
  parameter int AW  = 6,
  parameter int NB  = 2,
  parameter int BYW = 9,
  parameter int BB  = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [AW-1:0]        addr,
  input  logic                 proc_stb_n,
  input  logic                 ctrl_stb_n,
  input  logic                 adv_n,
  input  logic                 ce_main_n,
  input  logic                 ce_lo_n,
  input  logic                 ce_hi,
  input  logic                 wr_all_n,
  input  logic                 wr_byte_en_n,
  input  logic [NB-1:0]        byte_stb_n,
  input  logic                 oe_n,
  input  logic                 flow_thru,
  input  logic                 burst_linear,
  input  logic [NB*BYW-1:0]    wdata,
  output logic [NB*BYW-1:0]    rdata,
  output logic                 rdata_vld
);
  localparam int DW = NB * BYW;

  cmd_e          cmd;
  logic [NB-1:0] wmask;
  logic          active_q, rd_q, pv_q;
  logic [DW-1:0] pipe_q, arr_rd;
  logic [AW-1:0] cur_addr, nxt_addr;
  logic          no_wr;

  bsram_decode #(.NB(NB)) u_dec (
    .proc_stb_n   (proc_stb_n),
    .ctrl_stb_n   (ctrl_stb_n),
    .adv_n        (adv_n),
    .ce_main_n    (ce_main_n),
    .ce_lo_n      (ce_lo_n),
    .ce_hi        (ce_hi),
    .wr_all_n     (wr_all_n),
    .wr_byte_en_n (wr_byte_en_n),
    .byte_stb_n   (byte_stb_n),
    .active_q     (active_q),
    .cmd          (cmd),
    .wmask        (wmask)
  );

  bsram_burst #(.AW(AW), .BB(BB)) u_burst (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (cmd == CMD_START),
    .step      (cmd == CMD_STEP),
    .linear    (burst_linear),
    .load_addr (addr),
    .cur_addr  (cur_addr),
    .nxt_addr  (nxt_addr)
  );

  bsram_array #(.AW(AW), .NB(NB), .BYW(BYW)) u_arr (
    .clk   (clk),
    .we    (wmask),
    .waddr (nxt_addr),
    .wdata (wdata),
    .raddr (cur_addr),
    .rdata (arr_rd)
  );

  assign no_wr = (wmask == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      rd_q     <= 1'b0;
      pv_q     <= 1'b0;
      pipe_q   <= '0;
    end else begin
      pipe_q <= arr_rd;
      // in-flight read survives a deselect but not a write edge
      pv_q   <= active_q && rd_q && no_wr;
      unique case (cmd)
        CMD_DESEL: begin
          active_q <= 1'b0;
          rd_q     <= 1'b0;
        end
        CMD_START, CMD_STEP, CMD_HOLD: begin
          active_q <= 1'b1;
          rd_q     <= no_wr;
        end
        default: ;
      endcase
    end
  end

  assign rdata     = flow_thru ? arr_rd : pipe_q;
  assign rdata_vld = !oe_n && (flow_thru ? (active_q && rd_q) : pv_q);
endmodule

// File: rtl/bsram_ctrl_chk.sv
`timescale 1ns/1ps
module bsram_ctrl_chk
  import bsram_pkg::*;
#(
  parameter int AW = 6,
  parameter int NB = 2
) (
  input logic          clk,
  input logic          rst_n,
  input logic          oe_n,
  input logic          flow_thru,
  input logic          proc_stb_n,
  input logic          ce_main_n,
  input logic          rdata_vld,
  input cmd_e          cmd,
  input logic [NB-1:0] wmask,
  input logic [AW-1:0] cur_addr
);
  // R1
  rst_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> !rdata_vld);

  // R2
  proc_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!proc_stb_n && !ce_main_n) |-> (wmask == '0));

  // R6
  desel_flow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd == CMD_DESEL && flow_thru) |=> !rdata_vld);

  // R6
  desel_pipe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd == CMD_DESEL && !flow_thru) |=> ##1 !rdata_vld);

  // R7
  step_move_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd == CMD_STEP) |=> !$stable(cur_addr));

  // R8
  hold_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd == CMD_HOLD) |=> $stable(cur_addr));

  // R10
  oe_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    oe_n |-> !rdata_vld);

  // R11
  wr_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|wmask) |=> !rdata_vld);
endmodule

bind bsram_ctrl bsram_ctrl_chk #(.AW(AW), .NB(NB)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .oe_n       (oe_n),
  .flow_thru  (flow_thru),
  .proc_stb_n (proc_stb_n),
  .ce_main_n  (ce_main_n),
  .rdata_vld  (rdata_vld),
  .cmd        (cmd),
  .wmask      (wmask),
  .cur_addr   (cur_addr)
);

// File: tb/bsram_ctrl_bench.sv
`timescale 1ns/1ps
module bsram_ctrl_bench;
  localparam int AW = 6, NB = 2, BYW = 9, DW = NB * BYW;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rst_n, proc_stb_n, ctrl_stb_n, adv_n, ce_main_n, ce_lo_n, ce_hi;
  logic wr_all_n, wr_byte_en_n, oe_n, flow_thru, burst_linear, rdata_vld;
  logic [NB-1:0] byte_stb_n;
  logic [AW-1:0] addr;
  logic [DW-1:0] wdata, rdata;

  bsram_ctrl #(.AW(AW), .NB(NB), .BYW(BYW), .BB(2)) u_bsram_ctrl (
    .clk(clk), .rst_n(rst_n), .addr(addr), .proc_stb_n(proc_stb_n),
    .ctrl_stb_n(ctrl_stb_n), .adv_n(adv_n), .ce_main_n(ce_main_n),
    .ce_lo_n(ce_lo_n), .ce_hi(ce_hi), .wr_all_n(wr_all_n),
    .wr_byte_en_n(wr_byte_en_n), .byte_stb_n(byte_stb_n), .oe_n(oe_n),
    .flow_thru(flow_thru), .burst_linear(burst_linear), .wdata(wdata),
    .rdata(rdata), .rdata_vld(rdata_vld)
  );

  typedef struct {
    int            cyc;
    logic          vld;
    logic [DW-1:0] data;
    string         tag;
  } exp_t;

  exp_t          sbq[$];
  int            checks = 0, errors = 0, cyc = 0;
  bit            done = 0;
  logic [DW-1:0] ref_mem [1 << AW];

  localparam logic [DW-1:0] D0 = 18'h10A01, D1 = 18'h20B02, D2 = 18'h30C03,
                            D3 = 18'h01D04, P7 = 18'h2C3C3;

  always @(posedge clk) cyc = cyc + 1;

  task automatic compare(string tag, logic v, logic [DW-1:0] d);
    checks++;
    if (rdata_vld !== v || (v && rdata !== d)) begin
      errors++;
      $display("FAIL %s: vld=%0b data=%h expected vld=%0b data=%h",
               tag, rdata_vld, rdata, v, d);
    end
  endtask

  // monitor: pops expectations due in the current cycle
  always @(negedge clk) begin
    for (int i = sbq.size() - 1; i >= 0; i--) begin
      if (sbq[i].cyc == cyc) begin
        compare(sbq[i].tag, sbq[i].vld, sbq[i].data);
        sbq.delete(i);
      end
    end
  end

  task automatic expect_at(int lat, logic v, logic [DW-1:0] d, string tag);
    exp_t e;
    e.cyc = cyc + lat; e.vld = v; e.data = d; e.tag = tag;
    sbq.push_back(e);
  endtask

  task automatic wr_ref(logic [AW-1:0] a, logic [NB-1:0] m, logic [DW-1:0] d);
    for (int n = 0; n < NB; n++)
      if (m[n]) ref_mem[a][n*BYW +: BYW] = d[n*BYW +: BYW];
  endtask

  task automatic idle();
    proc_stb_n = 1; ctrl_stb_n = 1; adv_n = 1; ce_main_n = 0; ce_lo_n = 0;
    ce_hi = 1; wr_all_n = 1; wr_byte_en_n = 1; byte_stb_n = '1; wdata = '0;
  endtask

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic summary();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
  endtask

  initial begin
    #160000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog: run did not complete");
      summary();
      $finish;
    end
  end

  initial begin
    idle(); addr = '0; oe_n = 0; flow_thru = 1; burst_linear = 0; rst_n = 0;
    repeat (3) @(posedge clk);
    #1 compare("R1 in reset", 0, '0);
    rst_n = 1;
    tick();
    compare("R1 after release", 0, '0);

    // flow-through, interleaved write burst from 5: 5,4,7,6
    idle(); ctrl_stb_n = 0; addr = 5; wr_all_n = 0; wdata = D0;
    wr_ref(5, '1, D0); expect_at(1, 0, '0, "R11 write edge flow"); tick();
    idle(); adv_n = 0; wr_all_n = 0; wdata = D1;
    wr_ref(4, '1, D1); expect_at(1, 0, '0, "R12 cont write"); tick();
    idle(); adv_n = 0; wr_all_n = 0; wdata = D2;
    wr_ref(7, '1, D2); expect_at(1, 0, '0, "R12 cont write"); tick();
    idle(); adv_n = 0; wr_all_n = 0; wdata = D3;
    wr_ref(6, '1, D3); expect_at(1, 0, '0, "R12 cont write"); tick();
    idle(); expect_at(1, 1, ref_mem[6], "R8 hold after burst"); tick();

    // processor read with stray write enables
    idle(); proc_stb_n = 0; ctrl_stb_n = 0; wr_all_n = 0; wr_byte_en_n = 0;
    byte_stb_n = '0; wdata = '1; addr = 5;
    expect_at(1, 1, ref_mem[5], "R2 proc read ignores writes"); tick();
    idle(); adv_n = 0; expect_at(1, 1, ref_mem[4], "R7 interleave"); tick();
    idle(); adv_n = 0; expect_at(1, 1, ref_mem[7], "R7 interleave"); tick();
    idle(); adv_n = 0; expect_at(1, 1, ref_mem[6], "R7 interleave"); tick();
    idle(); expect_at(1, 1, ref_mem[6], "R8 suspend"); tick();
    idle(); expect_at(1, 1, ref_mem[6], "R8 suspend"); tick();

    // linear order from 5: 5,6,7,4
    idle(); proc_stb_n = 0; addr = 5;
    expect_at(1, 1, ref_mem[5], "R2 proc read"); tick();
    burst_linear = 1;
    idle(); adv_n = 0; expect_at(1, 1, ref_mem[6], "R7 linear"); tick();
    idle(); adv_n = 0; expect_at(1, 1, ref_mem[7], "R7 linear"); tick();
    idle(); adv_n = 0; expect_at(1, 1, ref_mem[4], "R7 linear"); tick();

    // byte-masked write, lane 0 only
    idle(); ctrl_stb_n = 0; addr = 5; wr_byte_en_n = 0; byte_stb_n = 2'b10;
    wdata = 18'h3F0AA; wr_ref(5, 2'b01, 18'h3F0AA);
    expect_at(1, 0, '0, "R5 byte write"); tick();
    idle(); proc_stb_n = 0; addr = 5;
    expect_at(1, 1, ref_mem[5], "R5 lane merge"); tick();
    idle(); ctrl_stb_n = 0; addr = 4; byte_stb_n = '0; wdata = '1;
    expect_at(1, 1, ref_mem[4], "R4 R5 no lane is read"); tick();

    // both strobes, write enables active: processor wins
    idle(); proc_stb_n = 0; ctrl_stb_n = 0; wr_all_n = 0; wdata = '1; addr = 7;
    expect_at(1, 1, ref_mem[7], "R4 proc priority"); tick();
    idle(); ce_main_n = 1; proc_stb_n = 0; addr = 0;
    expect_at(1, 1, ref_mem[7], "R3 blocked proc strobe"); tick();
    idle(); ce_main_n = 1; proc_stb_n = 0; ctrl_stb_n = 0; addr = 1;
    expect_at(1, 0, '0, "R6 R3 ctrl deselect"); tick();
    idle(); expect_at(1, 0, '0, "R6 stays deselected"); tick();

    // flow latency and asynchronous output enable
    idle(); proc_stb_n = 0; addr = 4;
    expect_at(1, 1, ref_mem[4], "R9 flow same cycle"); tick();
    oe_n = 1; #1 compare("R10 oe high", 0, '0);
    oe_n = 0; #1 compare("R10 oe low", 1, ref_mem[4]);
    idle(); ce_hi = 0; proc_stb_n = 0;
    expect_at(1, 0, '0, "R6 ce_hi deselect"); tick();
    idle(); ctrl_stb_n = 0; addr = 6;
    expect_at(1, 1, ref_mem[6], "R4 ctrl read"); tick();
    idle(); ctrl_stb_n = 0; ce_lo_n = 1;
    expect_at(1, 0, '0, "R6 ce_lo deselect"); tick();
    idle(); tick();

    // pipelined mode, linear order from 5
    flow_thru = 0; idle(); tick();
    idle(); proc_stb_n = 0; addr = 5;
    expect_at(1, 0, '0, "R9 pipe not yet");
    expect_at(2, 1, ref_mem[5], "R9 pipe one edge later"); tick();
    idle(); adv_n = 0; expect_at(2, 0, '0, "R11 in-flight read killed"); tick();
    idle(); adv_n = 0; wr_all_n = 0; wdata = P7; wr_ref(7, '1, P7);
    expect_at(2, 0, '0, "R11 pipe write"); tick();
    idle(); expect_at(2, 1, ref_mem[7], "R12 write hit stepped addr"); tick();
    idle(); adv_n = 0; expect_at(2, 1, ref_mem[4], "R7 pipe step"); tick();
    idle(); proc_stb_n = 0; ce_lo_n = 1;
    expect_at(2, 0, '0, "R6 pipe deselect"); tick();
    idle(); expect_at(2, 0, '0, "R6 pipe idle"); tick();
    repeat (3) tick();

    checks++;
    if (sbq.size() != 0) begin
      errors++;
      $display("FAIL scoreboard: %0d left expected 0", sbq.size());
    end
    done = 1;
    summary();
    $finish;
  end
endmodule